// File: doc/BRIEF.md
# Power Manager Sequencing State Machine

This block decides which of three power states a supply controller is in: DOWN, where the CPU rails are off; RUN, where they are up; and STANDBY, a low-power hold that software requests. Its inputs are already-digitised comparator flags, which report whether the system input voltage is above the turn-on threshold or below the turn-off threshold, and whether the die is cool enough to start or hot enough to stop. It also takes an enable pin, four CPU-rail fault flags and a narrow write port for a mode register. A millisecond tick provides the time base for qualifying the enable pin.

A short press of the enable pin turns the block on: the pin must stay high for a qualification window. A long press turns it off: the pin must go high after having been low, and then stay high for a much longer window. Software can also request power-off or standby by writing to the mode register. An over-temperature condition, or a rising fault on any CPU rail, forces DOWN. A fault also latches a lockout, and only a hard reset clears it. This stops a permanently faulty rail from making the block cycle on and off when the enable pin is tied high.

Top module: `pwr_seq_top`

## Requirements
- R1: While `rstN` is low and after its release, `state` is 0 (DOWN), `downEn` is 1, `runEn` and `stbyEn` are 0, and `ledOn` is 0 (LED off).
- R2: From DOWN, the block enters RUN on the clock after all three of these hold: `vinAboveOn` is high, `tempCool` is high, and `enPin` has been high for ON_TICKS `msTick` pulses. Fewer pulses, or either flag low, keeps it in DOWN.
- R3: Any cycle with `enPin` low restarts both the turn-on and the turn-off qualification counts.
- R4: From RUN or STANDBY, the block goes to DOWN on the clock after any of these: `vinBelowOff` is high; a write to address 0 has data bit 0 (OFF) set; or `enPin` has been high for OFF_TICKS pulses after having been low.
- R5: After a turn-off caused by a long press of the enable pin, the block does not turn on again until `enPin` has been low and then qualifies again.
- R6: `tempHot` high, or a low-to-high change on any bit of `cpuFail`, sends the block to DOWN and latches a lockout. While the lockout is set, RUN is not entered. Only `rstN` clears the lockout.
- R7: A write to address 0 with data bit 1 (STANDBY) set moves RUN to STANDBY. The same write in DOWN or STANDBY does nothing, and writes to any other address do nothing.
- R8: In STANDBY, `vinBelowOff` high returns the block to DOWN on the next clock.
- R9: When several events hold in the same cycle, the first of these takes effect: power-fail, power-off, standby-out, standby, power-on. A write of both bits goes to DOWN. A power-fail at the same time as a software off still locks. `vinBelowOff` in DOWN blocks turn-on.
- R10: Exactly one of `downEn`, `runEn` and `stbyEn` is high, matching `state` (0 DOWN, 1 RUN, 2 STANDBY). `ledOn` is high only in RUN.
- R11: After a software off, if the turn-on conditions still hold (for example with the pin tied high), the block re-enters RUN on the clock after it reaches DOWN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hard reset, active low, asynchronous |
| msTick | input | 1 | One-cycle pulse per millisecond |
| enPin | input | 1 | Enable pin, active high |
| vinAboveOn | input | 1 | Input voltage above turn-on threshold |
| vinBelowOff | input | 1 | Input voltage below turn-off threshold |
| tempCool | input | 1 | Die temperature below start limit |
| tempHot | input | 1 | Die temperature above shutdown limit |
| cpuFail | input | NUM_FAIL | CPU-rail fault flags |
| regWrEn | input | 1 | Mode register write strobe |
| regAddr | input | ADDR_W | Write address |
| regWrData | input | 2 | Write data: bit 0 OFF, bit 1 STANDBY |
| state | output | 2 | Current state: 0 DOWN, 1 RUN, 2 STANDBY |
| downEn | output | 1 | High in DOWN |
| runEn | output | 1 | High in RUN |
| stbyEn | output | 1 | High in STANDBY |
| ledOn | output | 1 | LED drive, 1 = lit |

## Verification
The assertions check, on every cycle, the transitions that follow directly from a flag. A high `vinBelowOff`, a high `tempHot` or a rising rail fault must be followed by DOWN. RUN may be entered from DOWN only when the voltage, temperature and pin conditions held on the previous cycle, and STANDBY is never entered from DOWN. The assertions also check that the state enables stay one-hot. Some behaviours depend on history, so only the directed scenarios show them: the exact tick counts of both press windows, the counter restart on a pin glitch, the refusal to turn on after a long press, the lockout lasting until hard reset, and the priority between events that arrive in the same cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    PS_DOWN = 2'd0,
    PS_RUN  = 2'd1,
    PS_STBY = 2'd2
  } pwrState_t;

  // qualified events handed from datapath to control, one cycle wide
  typedef struct packed {
    logic powerFail;
    logic powerOff;
    logic stbyOut;
    logic stbyReq;
    logic powerOn;
  } evtStrobe_t;
endpackage

// File: rtl/pwr_seq_datapath.sv
module pwr_seq_datapath
  import pwr_seq_pkg::*;
#(
  parameter int ON_TICKS  = 100,
  parameter int OFF_TICKS = 5000,
  parameter int NUM_FAIL  = 4,
  parameter int ADDR_W    = 8,
  parameter int MODE_ADDR = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                msTick,
  input  logic                enPin,
  input  logic                vinAboveOn,
  input  logic                vinBelowOff,
  input  logic                tempCool,
  input  logic                tempHot,
  input  logic [NUM_FAIL-1:0] cpuFail,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [1:0]          regWrData,
  output evtStrobe_t          evt
);
  localparam int CNT_W = $clog2(OFF_TICKS + 1);
  localparam logic [CNT_W-1:0] ON_LIM  = CNT_W'(ON_TICKS);
  localparam logic [CNT_W-1:0] OFF_LIM = CNT_W'(OFF_TICKS);
  localparam logic [CNT_W-1:0] OFF_PRE = CNT_W'(OFF_TICKS - 1);
  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);

  logic [CNT_W-1:0] onCnt, offCnt;
  logic             longDone;   // long press seen since pin last low
  logic             armed;      // pin has been low at least once
  logic             offFire;
  logic             onQual;
  logic             modeWr;
  logic [NUM_FAIL-1:0] failPrev;
  logic [NUM_FAIL-1:0] failRise;

  // enable-pin qualification timers
  assign offFire = enPin && msTick && armed && (offCnt == OFF_PRE);
  assign onQual  = enPin && (onCnt == ON_LIM) && !longDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onCnt    <= '0;
      offCnt   <= '0;
      longDone <= 1'b0;
      armed    <= 1'b0;
    end else if (!enPin) begin
      onCnt    <= '0;
      offCnt   <= '0;
      longDone <= 1'b0;
      armed    <= 1'b1;
    end else if (msTick) begin
      if (onCnt != ON_LIM) onCnt <= onCnt + 1'b1;
      if (armed && offCnt != OFF_LIM) offCnt <= offCnt + 1'b1;
      if (offFire) longDone <= 1'b1;
    end
  end

  // per-rail rising-edge detection
  for (genvar i = 0; i < NUM_FAIL; i++) begin : g_fail
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) failPrev[i] <= 1'b0;
      else       failPrev[i] <= cpuFail[i];
    end
    assign failRise[i] = cpuFail[i] && !failPrev[i];
  end

  // mode register: bits act as self-clearing pulses
  assign modeWr = regWrEn && (regAddr == MODE_A);

  always_comb begin
    evt.powerFail = tempHot || (|failRise);
    evt.powerOff  = vinBelowOff || offFire || (modeWr && regWrData[0]);
    evt.stbyOut   = vinBelowOff;
    evt.stbyReq   = modeWr && regWrData[1];
    evt.powerOn   = vinAboveOn && tempCool && onQual;
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  evtStrobe_t evt,
  output pwrState_t  curState
);
  pwrState_t nextState;
  logic      failLock;
  logic      nextLock;

  // fixed priority: fail, off, standby-out, standby, on
  always_comb begin
    nextState = curState;
    nextLock  = failLock;
    if (evt.powerFail) begin
      nextState = PS_DOWN;
      nextLock  = 1'b1;
    end else if (evt.powerOff || evt.stbyOut) begin
      nextState = PS_DOWN;
    end else if (evt.stbyReq && curState == PS_RUN) begin
      nextState = PS_STBY;
    end else if (evt.powerOn && curState == PS_DOWN && !failLock) begin
      nextState = PS_RUN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= PS_DOWN;
      failLock <= 1'b0;
    end else begin
      curState <= nextState;
      failLock <= nextLock;
    end
  end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int ON_TICKS  = 100,
  parameter int OFF_TICKS = 5000,
  parameter int NUM_FAIL  = 4,
  parameter int ADDR_W    = 8,
  parameter int MODE_ADDR = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                msTick,
  input  logic                enPin,
  input  logic                vinAboveOn,
  input  logic                vinBelowOff,
  input  logic                tempCool,
  input  logic                tempHot,
  input  logic [NUM_FAIL-1:0] cpuFail,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [1:0]          regWrData,
  output logic [1:0]          state,
  output logic                downEn,
  output logic                runEn,
  output logic                stbyEn,
  output logic                ledOn
);
  evtStrobe_t evt;
  pwrState_t  curState;

  pwr_seq_datapath #(
    .ON_TICKS(ON_TICKS), .OFF_TICKS(OFF_TICKS), .NUM_FAIL(NUM_FAIL),
    .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .msTick(msTick), .enPin(enPin),
    .vinAboveOn(vinAboveOn), .vinBelowOff(vinBelowOff),
    .tempCool(tempCool), .tempHot(tempHot), .cpuFail(cpuFail),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .evt(evt)
  );

  pwr_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .curState(curState)
  );

  assign state  = curState;
  assign downEn = (curState == PS_DOWN);
  assign runEn  = (curState == PS_RUN);
  assign stbyEn = (curState == PS_STBY);
  assign ledOn  = (curState == PS_RUN);
endmodule

// File: rtl/pwr_seq_checker.sv
module pwr_seq_checker #(
  parameter int NUM_FAIL = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                enPin,
  input logic                vinAboveOn,
  input logic                vinBelowOff,
  input logic                tempCool,
  input logic                tempHot,
  input logic [NUM_FAIL-1:0] cpuFail,
  input logic [1:0]          state,
  input logic                downEn,
  input logic                runEn,
  input logic                stbyEn,
  input logic                ledOn
);
  a_r10_onehot_enables: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({downEn, runEn, stbyEn}));

  a_r10_led_only_run: assert property (@(posedge clk) disable iff (!rstN)
    ledOn |-> runEn);

  a_r4_vin_low_goes_down: assert property (@(posedge clk) disable iff (!rstN)
    vinBelowOff |=> (state == 2'd0));

  a_r6_hot_goes_down: assert property (@(posedge clk) disable iff (!rstN)
    tempHot |=> (state == 2'd0));

  a_r6_rail_rise_goes_down: assert property (@(posedge clk) disable iff (!rstN)
    ((cpuFail & ~$past(cpuFail)) != '0) |=> (state == 2'd0));

  a_r2_run_needs_conditions: assert property (@(posedge clk) disable iff (!rstN)
    (state == 2'd0) |=> (state != 2'd1 || $past(vinAboveOn && tempCool && enPin)));

  a_r7_no_standby_from_down: assert property (@(posedge clk) disable iff (!rstN)
    (state == 2'd0) |=> (state != 2'd2));
endmodule

bind pwr_seq_top pwr_seq_checker #(.NUM_FAIL(NUM_FAIL)) u_chk (
  .clk(clk), .rstN(rstN), .enPin(enPin), .vinAboveOn(vinAboveOn),
  .vinBelowOff(vinBelowOff), .tempCool(tempCool), .tempHot(tempHot),
  .cpuFail(cpuFail), .state(state), .downEn(downEn), .runEn(runEn),
  .stbyEn(stbyEn), .ledOn(ledOn)
);

// File: tb/tb_pwr_seq_top.sv
module tb_pwr_seq_top;
  localparam int ON_T  = 4;
  localparam int OFF_T = 10;
  localparam int NF    = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          msTick = 1'b0;
  logic          enPin = 1'b0;
  logic          vinAboveOn = 1'b1;
  logic          vinBelowOff = 1'b0;
  logic          tempCool = 1'b1;
  logic          tempHot = 1'b0;
  logic [NF-1:0] cpuFail = '0;
  logic          regWrEn = 1'b0;
  logic [7:0]    regAddr = '0;
  logic [1:0]    regWrData = '0;
  logic [1:0]    state;
  logic          downEn, runEn, stbyEn, ledOn;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  pwr_seq_top #(.ON_TICKS(ON_T), .OFF_TICKS(OFF_T), .NUM_FAIL(NF)) dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .enPin(enPin),
    .vinAboveOn(vinAboveOn), .vinBelowOff(vinBelowOff),
    .tempCool(tempCool), .tempHot(tempHot), .cpuFail(cpuFail),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .state(state), .downEn(downEn), .runEn(runEn), .stbyEn(stbyEn),
    .ledOn(ledOn)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      msTick = 1'b1;
      @(negedge clk);
      msTick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    vinAboveOn = 1'b1; vinBelowOff = 1'b0; tempCool = 1'b1; tempHot = 1'b0;
    cpuFail = '0; enPin = 1'b0; msTick = 1'b0; regWrEn = 1'b0;
    step(3);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic bringUp();
    enPin = 1'b0; step(1);
    enPin = 1'b1; tick(ON_T);
  endtask

  task automatic t_reset();
    rstN = 1'b0; step(2);
    chk("R1 state in reset", state, 0);
    chk("R1 led in reset", ledOn, 0);
    chk("R1 downEn in reset", downEn, 1);
    rstN = 1'b1; step(2);
    chk("R1 state after reset", state, 0);
    chk("R1 enables after reset", {runEn, stbyEn}, 0);
  endtask

  task automatic t_power_on();
    doReset();
    tempCool = 1'b0;
    enPin = 1'b1; tick(ON_T - 1);
    chk("R2 short press stays down", state, 0);
    tick(1);
    chk("R2 no turn-on while warm", state, 0);
    tempCool = 1'b1; step(1);
    chk("R2 turn-on once cool", state, 1);
    chk("R10 runEn in RUN", runEn, 1);
    chk("R10 led lit in RUN", ledOn, 1);
  endtask

  task automatic t_glitch();
    doReset();
    enPin = 1'b1; tick(ON_T - 1);
    enPin = 1'b0; step(1);
    enPin = 1'b1; tick(ON_T - 1);
    chk("R3 glitch restarts count", state, 0);
    tick(1);
    chk("R3 full count after glitch", state, 1);
  endtask

  task automatic t_standby();
    doReset();
    tempCool = 1'b0;
    enPin = 1'b1; tick(ON_T);
    wr(8'h00, 2'b10);
    chk("R7 standby ignored in DOWN", state, 0);
    tempCool = 1'b1; step(1);
    chk("R7 run reached", state, 1);
    wr(8'h01, 2'b10);
    chk("R7 other address ignored", state, 1);
    wr(8'h00, 2'b10);
    chk("R7 standby from RUN", state, 2);
    chk("R10 stbyEn and led", {stbyEn, ledOn}, 2'b10);
    wr(8'h00, 2'b10);
    chk("R7 standby write in STANDBY", state, 2);
    vinBelowOff = 1'b1; step(1);
    chk("R8 standby-out to DOWN", state, 0);
    vinBelowOff = 1'b0; step(1);
    chk("R11 back to RUN with pin high", state, 1);
  endtask

  task automatic t_sw_off();
    doReset();
    bringUp();
    chk("R2 run before off", state, 1);
    wr(8'h00, 2'b01);
    chk("R4 software off", state, 0);
    step(1);
    chk("R11 re-entry after software off", state, 1);
    wr(8'h00, 2'b11);
    chk("R9 off beats standby", state, 0);
    vinBelowOff = 1'b1; step(3);
    chk("R9 low input blocks turn-on", state, 0);
    vinBelowOff = 1'b0; step(1);
    chk("R9 turn-on after input recovers", state, 1);
    vinBelowOff = 1'b1; step(1);
    chk("R4 low input turns off", state, 0);
    vinBelowOff = 1'b0;
  endtask

  task automatic t_long_press();
    doReset();
    bringUp();
    tick(OFF_T - ON_T - 1);
    chk("R4 one tick short of long press", state, 1);
    tick(1);
    chk("R4 long press turns off", state, 0);
    tick(3);
    chk("R5 no restart while held", state, 0);
    bringUp();
    chk("R5 restart after release", state, 1);
  endtask

  task automatic t_fail();
    doReset();
    bringUp();
    cpuFail[2] = 1'b1; step(1);
    chk("R6 rail fault to DOWN", state, 0);
    enPin = 1'b0; step(1); enPin = 1'b1;
    tick(ON_T + 2);
    chk("R6 locked while fault held", state, 0);
    cpuFail = '0;
    enPin = 1'b0; step(1); enPin = 1'b1;
    tick(ON_T + 2);
    chk("R6 locked after fault cleared", state, 0);
    doReset();
    bringUp();
    chk("R6 hard reset clears lock", state, 1);
    tempHot = 1'b1; step(1);
    chk("R6 over-temperature to DOWN", state, 0);
    tempHot = 1'b0;
    bringUp();
    chk("R6 locked after over-temperature", state, 0);
    doReset();
    bringUp();
    tempHot = 1'b1;
    wr(8'h00, 2'b01);
    tempHot = 1'b0;
    bringUp();
    chk("R9 fail beats off and locks", state, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    t_reset();
    t_power_on();
    t_glitch();
    t_standby();
    t_sw_off();
    t_long_press();
    t_fail();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule